// File: doc/BRIEF.md
# Single-Shot Transient Capture Buffer

This block sits behind a fast sampling converter. It stores one burst of multi-bit samples at the fast sample rate and then keeps them. Software or a control sequencer first arms the buffer. The first trigger seen while armed starts the capture. Each bit lane of the sample word goes into its own shift register, and the capture stops by itself once every stage of those registers is filled.

After the burst is complete the buffer is frozen. No sample, trigger, arm or disarm command can change it. A readout request opens a slow drain phase. In that phase the samples come out one per readout clock-enable, oldest first. After the last sample has been delivered the buffer goes back to idle, ready for a new arm.

A disarm command given before the capture completes abandons the attempt and returns the buffer to idle.

Top module: `transient_capture_buffer`

## Requirements
- R1: After reset the buffer is idle: `st_armed`, `st_capturing`, `st_full`, `rd_valid` and `rd_done` are all low. At no time is more than one of `st_armed`, `st_capturing`, `st_full` high.
- R2: `arm_cmd` in idle makes `st_armed` high from the next cycle. `arm_cmd` in any other state has no effect.
- R3: A `trig` while armed captures the sample present in that same cycle as the first sample. The following DEPTH-1 consecutive samples are then taken without gaps. `st_capturing` is high for the DEPTH-1 cycles after the trigger cycle, and `st_full` rises in the cycle after that. A `trig` outside the armed state is ignored.
- R4: `disarm_cmd` while armed or capturing returns the buffer to idle in the next cycle, with no status flag high. A disarm wins over a trigger in the same cycle.
- R5: While full, the sample input, `trig`, `arm_cmd` and `disarm_cmd` have no effect. `st_full` stays high and the stored samples are read out unchanged.
- R6: `rd_start` while full and not yet reading starts the drain. From the next cycle `rd_valid` is high and `rd_data` shows the oldest stored sample. Each cycle with `rd_en` high advances `rd_data` to the next sample in capture order. Without `rd_en`, `rd_data` holds.
- R7: In the cycle after the DEPTH-th accepted `rd_en`, `rd_valid` and `st_full` are low and `rd_done` is high for exactly one cycle. The buffer is then idle and can be armed again.
- R8: `rd_start` outside the full, not-reading state and `rd_en` outside the drain phase are ignored. They neither start a drain nor advance the stored data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sample clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_data | input | SAMPLE_W | Converter sample word, bit i goes to lane i |
| arm_cmd | input | 1 | Arm request |
| disarm_cmd | input | 1 | Abandon an armed or running capture |
| trig | input | 1 | Capture trigger |
| rd_start | input | 1 | Readout request |
| rd_en | input | 1 | Slow readout clock-enable, one sample per high cycle |
| rd_data | output | SAMPLE_W | Current readout sample |
| rd_valid | output | 1 | Drain phase active, `rd_data` meaningful |
| rd_done | output | 1 | One-cycle pulse after the final sample is read |
| st_armed | output | 1 | Waiting for a trigger |
| st_capturing | output | 1 | Burst capture in progress |
| st_full | output | 1 | Burst stored, held or draining |

## Verification
The bench goes after capture length and alignment. A design that takes one sample too many or too few, or skips the trigger-cycle sample, returns a shifted counting pattern on readout. It also hammers the buffer with fresh samples, triggers, arm and disarm while full. A design that lets data leak in would return corrupted values rather than the stored ramp.

Further checks cover a disarm together with a trigger, a disarm in mid-burst, readout enables given before the drain starts, and stalls between enables. A design that gets these wrong would capture anyway, lose the oldest sample, or repeat or skip samples. The final enable must end in a single done pulse and an idle buffer.

// File: rtl/tcb_pkg.sv
package tcb_pkg;

    localparam int unsigned SMP_W_DEF = 6;
    localparam int unsigned DEPTH_DEF = 32;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_ARMED   = 3'd1,
        ST_CAPTURE = 3'd2,
        ST_HELD    = 3'd3,
        ST_READOUT = 3'd4
    } tcb_state_e;

    typedef struct packed {
        logic cap_shift;
        logic rd_shift;
    } tcb_shift_t;

    typedef struct packed {
        logic armed;
        logic capturing;
        logic full;
        logic draining;
    } tcb_status_t;

    function automatic tcb_status_t status_of(tcb_state_e s);
        tcb_status_t r;
        r.armed     = (s == ST_ARMED);
        r.capturing = (s == ST_CAPTURE);
        r.full      = (s == ST_HELD) || (s == ST_READOUT);
        r.draining  = (s == ST_READOUT);
        return r;
    endfunction

endpackage

// File: rtl/tcb_ctrl.sv
module tcb_ctrl
    import tcb_pkg::*;
#(
    parameter int unsigned DEPTH = DEPTH_DEF
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       arm_cmd,
    input  logic       disarm_cmd,
    input  logic       trig,
    input  logic       rd_start,
    input  logic       rd_en,
    output tcb_shift_t shift,
    output tcb_state_e state,
    output logic       done
);
    localparam int unsigned CW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [CW-1:0] LAST = CW'(DEPTH - 1);
    localparam logic [CW-1:0] ONE  = CW'(1);

    tcb_state_e    state_q, state_n;
    logic [CW-1:0] cnt_q, cnt_n;
    logic          done_n;
    tcb_shift_t    shift_n;

    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        done_n  = 1'b0;
        shift_n = '0;
        case (state_q)
            ST_IDLE: begin
                if (arm_cmd) state_n = ST_ARMED;
            end
            ST_ARMED: begin
                if (disarm_cmd) begin
                    state_n = ST_IDLE;
                end else if (trig) begin
                    shift_n.cap_shift = 1'b1;
                    if (DEPTH == 1) begin
                        state_n = ST_HELD;
                        cnt_n   = '0;
                    end else begin
                        state_n = ST_CAPTURE;
                        cnt_n   = ONE;
                    end
                end
            end
            ST_CAPTURE: begin
                if (disarm_cmd) begin
                    state_n = ST_IDLE;
                    cnt_n   = '0;
                end else begin
                    shift_n.cap_shift = 1'b1;
                    if (cnt_q == LAST) begin
                        state_n = ST_HELD;
                        cnt_n   = '0;
                    end else begin
                        cnt_n = cnt_q + ONE;
                    end
                end
            end
            ST_HELD: begin
                if (rd_start) state_n = ST_READOUT;
            end
            ST_READOUT: begin
                if (rd_en) begin
                    shift_n.rd_shift = 1'b1;
                    if (cnt_q == LAST) begin
                        state_n = ST_IDLE;
                        cnt_n   = '0;
                        done_n  = 1'b1;
                    end else begin
                        cnt_n = cnt_q + ONE;
                    end
                end
            end
            default: begin
                state_n = ST_IDLE;
                cnt_n   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            done    <= 1'b0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
            done    <= done_n;
        end
    end

    assign shift = shift_n;
    assign state = state_q;

    // Counter stays inside the register depth
    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        (cnt_q <= LAST)) else $error("counter out of range"); // R3

    // Capture and drain shifting never coincide
    AST_SHIFT_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(shift.cap_shift && shift.rd_shift)) else $error("shift overlap"); // R5

endmodule

// File: rtl/tcb_lane.sv
module tcb_lane #(
    parameter int unsigned DEPTH = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic shift_en,
    input  logic din,
    output logic tail
);
    logic [DEPTH-1:0] sr_q;

    generate
        if (DEPTH == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst)           sr_q <= '0;
                else if (shift_en) sr_q <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst)           sr_q <= '0;
                else if (shift_en) sr_q <= {sr_q[DEPTH-2:0], din};
            end
        end
    endgenerate

    assign tail = sr_q[DEPTH-1];

    // Without a shift the lane contents are frozen
    AST_LANE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(tail)) else $error("lane moved without shift"); // R5

endmodule

// File: rtl/transient_capture_buffer.sv
module transient_capture_buffer
    import tcb_pkg::*;
#(
    parameter int unsigned SAMPLE_W = SMP_W_DEF,
    parameter int unsigned DEPTH    = DEPTH_DEF
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic                arm_cmd,
    input  logic                disarm_cmd,
    input  logic                trig,
    input  logic                rd_start,
    input  logic                rd_en,
    output logic [SAMPLE_W-1:0] rd_data,
    output logic                rd_valid,
    output logic                rd_done,
    output logic                st_armed,
    output logic                st_capturing,
    output logic                st_full
);
    tcb_shift_t  shift;
    tcb_state_e  state;
    tcb_status_t stat;

    tcb_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .arm_cmd    (arm_cmd),
        .disarm_cmd (disarm_cmd),
        .trig       (trig),
        .rd_start   (rd_start),
        .rd_en      (rd_en),
        .shift      (shift),
        .state      (state),
        .done       (rd_done)
    );

    // Acquisition switch per lane: sample bit in during capture, zero during drain
    generate
        for (genvar i = 0; i < SAMPLE_W; i++) begin : g_lane
            logic lane_din;
            assign lane_din = shift.cap_shift ? smp_data[i] : 1'b0;
            tcb_lane #(.DEPTH(DEPTH)) u_lane (
                .clk      (clk),
                .rst      (rst),
                .shift_en (shift.cap_shift | shift.rd_shift),
                .din      (lane_din),
                .tail     (rd_data[i])
            );
        end
    endgenerate

    assign stat         = status_of(state);
    assign st_armed     = stat.armed;
    assign st_capturing = stat.capturing;
    assign st_full      = stat.full;
    assign rd_valid     = stat.draining;

    AST_ONE_STATUS: assert property (@(posedge clk) disable iff (rst)
        $onehot0({st_armed, st_capturing, st_full})) else $error("status overlap"); // R1

    AST_ARM_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
        $rose(st_armed) |-> $past(arm_cmd)) else $error("armed without request"); // R2

    AST_FULL_AFTER_BURST: assert property (@(posedge clk) disable iff (rst)
        $rose(st_full) |-> ($past(st_capturing) || (DEPTH == 1))) else $error("full without burst"); // R3

    AST_DISARM_IDLE: assert property (@(posedge clk) disable iff (rst)
        (st_armed || st_capturing) && disarm_cmd |=> !st_armed && !st_capturing && !st_full)
        else $error("disarm ignored"); // R4

    AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (rst)
        st_full && !rd_valid |=> $stable(rd_data) && st_full) else $error("held data changed"); // R5

    AST_READ_STALL: assert property (@(posedge clk) disable iff (rst)
        rd_valid && !rd_en |=> $stable(rd_data) && rd_valid) else $error("drain moved on stall"); // R6

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        rd_done |=> !rd_done && !st_full && !rd_valid) else $error("done not a pulse"); // R7

    AST_READ_GATED: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_valid) |-> $past(rd_start) && $past(st_full)) else $error("drain without request"); // R8

endmodule

// File: tb/transient_capture_buffer_test.sv
module transient_capture_buffer_test;
    localparam int CLK_P = 10;
    localparam int SW    = 6;
    localparam int DP    = 32;
    localparam int MASK  = (1 << SW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [SW-1:0] smp_data = '0;
    logic          arm_cmd = 1'b0, disarm_cmd = 1'b0, trig = 1'b0;
    logic          rd_start = 1'b0, rd_en = 1'b0;
    logic [SW-1:0] rd_data;
    logic          rd_valid, rd_done, st_armed, st_capturing, st_full;

    int n_chk = 0;
    int n_bad = 0;

    transient_capture_buffer #(.SAMPLE_W(SW), .DEPTH(DP)) uut (
        .clk(clk), .rst(rst), .smp_data(smp_data), .arm_cmd(arm_cmd),
        .disarm_cmd(disarm_cmd), .trig(trig), .rd_start(rd_start), .rd_en(rd_en),
        .rd_data(rd_data), .rd_valid(rd_valid), .rd_done(rd_done),
        .st_armed(st_armed), .st_capturing(st_capturing), .st_full(st_full)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        chk("R1 armed", st_armed, 0);
        chk("R1 capturing", st_capturing, 0);
        chk("R1 full", st_full, 0);
        chk("R1 valid", rd_valid, 0);
        chk("R1 done", rd_done, 0);
    endtask

    task automatic t_idle_ignores();
        trig = 1'b1; rd_start = 1'b1; rd_en = 1'b1;
        tick();
        trig = 1'b0; rd_start = 1'b0; rd_en = 1'b0;
        chk("R3 trig in idle", st_capturing, 0);
        chk("R8 rd_start in idle", rd_valid, 0);
        arm_cmd = 1'b1;
        tick();
        chk("R2 armed", st_armed, 1);
        tick();
        arm_cmd = 1'b0;
        chk("R2 arm while armed", st_armed, 1);
    endtask

    task automatic t_disarm();
        trig = 1'b1; disarm_cmd = 1'b1;
        tick();
        trig = 1'b0; disarm_cmd = 1'b0;
        chk("R4 disarm beats trig armed", st_armed, 0);
        chk("R4 disarm beats trig cap", st_capturing, 0);
        arm_cmd = 1'b1;
        tick();
        arm_cmd = 1'b0; trig = 1'b1; smp_data = 6'd9;
        tick();
        trig = 1'b0;
        chk("R3 capturing after trig", st_capturing, 1);
        repeat (5) tick();
        disarm_cmd = 1'b1;
        tick();
        disarm_cmd = 1'b0;
        chk("R4 mid-burst capturing", st_capturing, 0);
        chk("R4 mid-burst full", st_full, 0);
        chk("R4 mid-burst armed", st_armed, 0);
    endtask

    task automatic t_capture(input int base);
        int cap_cycles = 0;
        arm_cmd = 1'b1;
        tick();
        arm_cmd = 1'b0;
        trig = 1'b1; smp_data = SW'(base);
        for (int k = 1; k < DP; k++) begin
            tick();
            trig = 1'b0;
            if (st_capturing) cap_cycles++;
            chk("R3 not full early", st_full, 0);
            smp_data = SW'((base + k) & MASK);
        end
        tick();
        chk("R3 capture cycles", cap_cycles, DP - 1);
        chk("R3 full after burst", st_full, 1);
        chk("R3 capturing ends", st_capturing, 0);
        // R5: poke every control while full
        for (int k = 0; k < 4; k++) begin
            smp_data = SW'(k * 13);
            trig = 1'b1; arm_cmd = (k == 1); disarm_cmd = (k == 2);
            tick();
            chk("R5 full held", st_full, 1);
            chk("R5 no arm while full", st_armed, 0);
        end
        trig = 1'b0; arm_cmd = 1'b0; disarm_cmd = 1'b0;
        // R8: rd_en before the drain starts must not advance
        rd_en = 1'b1;
        repeat (2) tick();
        rd_en = 1'b0;
        chk("R8 rd_en in held", rd_valid, 0);
    endtask

    task automatic t_readout(input int base);
        rd_start = 1'b1;
        tick();
        rd_start = 1'b0;
        chk("R6 valid", rd_valid, 1);
        chk("R6 oldest first", rd_data, base & MASK);
        tick();
        chk("R6 stall holds", rd_data, base & MASK);
        for (int k = 1; k <= DP; k++) begin
            rd_en = 1'b1;
            tick();
            rd_en = 1'b0;
            if (k < DP) begin
                chk("R6 order", rd_data, (base + k) & MASK);
                chk("R6 still valid", rd_valid, 1);
                if (k % 7 == 0) begin
                    tick();
                    chk("R6 stall", rd_data, (base + k) & MASK);
                end
            end
        end
        chk("R7 valid off", rd_valid, 0);
        chk("R7 done", rd_done, 1);
        chk("R7 full off", st_full, 0);
        tick();
        chk("R7 done one cycle", rd_done, 0);
        rd_en = 1'b1;
        tick();
        rd_en = 1'b0;
        chk("R8 rd_en in idle", rd_valid, 0);
    endtask

    initial begin
        #(CLK_P * 100000);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_idle_ignores();
        t_disarm();
        t_capture(40);
        t_readout(40);
        t_capture(3);
        t_readout(3);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule